// File: doc/BRIEF.md
# Boolean Pattern Match Engine

This block watches a small group of digital inputs and evaluates a programmable sum-of-products expression over them. Each input is brought into the clock domain through a two-flop synchroniser. The previous synchronised value is kept as well, so rising and falling edges can be seen. Eight slices each pick one input and give it a condition, which may be a level or an edge. A slice whose end flag is set closes a product term. Every slice before it, back to the previous closing slice, is ANDed into that term.

Each product term drives the match output bit of the slice that closes it. The OR of all terms drives a single interrupt line. Edge conditions come in two kinds. A sticky edge is remembered until the term that contains it matches. An event edge counts only in the cycle in which it is seen.

A mode input chooses between this engine and a simple per-pin interrupt scheme that lives outside the block. While the engine is not selected, its outputs stay low and it remembers no edges.

Top module: `pattern_match_engine`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every match bit and the interrupt are 0.
- R2: The outputs are registered, and an input change passes two synchroniser flops first. An input change driven before clock edge k therefore first shows on the outputs after edge k+2. A condition change shows after edge k.
- R3: Condition code 3'b100 is true while the selected input is high. Code 3'b101 is true while it is low.
- R4: All slices of one product term must be true together for the term to match. Slice i belongs to the term closed by the first slice j ≥ i whose end flag (term_end_i[j]) is 1.
- R5: match_o[j] is 1 only for a slice j that closes a term, and only while that term matches. irq_o is the OR of all match bits, so two terms may be reported at once.
- R6: Code 3'b001 (sticky rising) is true from a rising edge of the selected input until its term matches. The memory is cleared in that cycle, so a level-only partner gives a one-cycle match.
- R7: Code 3'b010 (sticky falling) and code 3'b011 (sticky, either edge) behave the same way for falling edges and for both edges.
- R8: Code 3'b111 (event) is true only in the single cycle in which a rising edge of the selected input is seen. It is not remembered, and falling edges are ignored.
- R9: Code 3'b000 is always true. Code 3'b110 is never true.
- R10: Slice NUM_SLICES-1 always closes a term, whatever its end flag says.
- R11: While mode_i is 0, all match bits and the interrupt are 0. No sticky edge is kept, so an edge seen while the mode was 0 does not count once mode_i returns to 1.
- R12: Slice s evaluates only the input whose index is given in sel_i[s*IDX_W +: IDX_W]. Other inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 1 selects the pattern engine, 0 the per-pin mode (engine idle) |
| in_i | input | NUM_IN | Asynchronous inputs IN0..IN(NUM_IN-1) |
| sel_i | input | NUM_SLICES*IDX_W | Per-slice input index |
| cond_i | input | NUM_SLICES*3 | Per-slice condition code |
| term_end_i | input | NUM_SLICES | Per-slice end-of-term flag |
| match_o | output | NUM_SLICES | Per-term match, at the closing slice's bit |
| irq_o | output | 1 | OR of all product terms |

## Verification
The assertions assume that the configuration inputs (sel_i, cond_i, term_end_i, mode_i) are driven synchronously and held steady between changes. The one-cycle relations between a match bit and the end flag or mode sampled on the previous edge rely on that. The stimulus changes configuration only on the falling clock edge. It returns all inputs to zero and lets the synchroniser settle before it reprograms the slices, so no edge from one scenario can leak into the next. Inputs are also changed only on falling edges and held for several cycles, except for the deliberate one-cycle pulse used to exercise sticky edge memory.

// File: rtl/pm_pkg.sv
// Shared types for the pattern match engine.
// Assumes a 3-bit condition code per slice.
package pm_pkg;

    typedef enum logic [2:0] {
        PM_ALWAYS  = 3'b000,
        PM_RISE_ST = 3'b001,
        PM_FALL_ST = 3'b010,
        PM_EDGE_ST = 3'b011,
        PM_HIGH    = 3'b100,
        PM_LOW     = 3'b101,
        PM_NEVER   = 3'b110,
        PM_EVENT   = 3'b111
    } pm_cond_e;

    localparam int unsigned PM_COND_W = 3;

endpackage

// File: rtl/pm_sync.sv
// Two-flop synchroniser plus a history flop for edge detection.
// Assumes the inputs are asynchronous level signals. The outputs are the current
// and previous synchronised values; reset clears all stages.
module pm_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    // Shift raw inputs through two sync stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/pm_slice.sv
// One bit slice: chooses an input, evaluates its condition and keeps a sticky
// edge flag. Assumes term_hit_i reports whether this slice's own product term
// matches in the current cycle; the flag is cleared on that cycle.
module pm_slice
    import pm_pkg::*;
#(
    parameter int unsigned NUM_IN = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [IDX_W-1:0]  sel_i,
    input  pm_cond_e          cond_i,
    input  logic [NUM_IN-1:0] cur_i,
    input  logic [NUM_IN-1:0] prev_i,
    input  logic              term_hit_i,
    output logic              ok_o
);
    logic bit_now;
    logic bit_old;
    logic rise;
    logic fall;
    logic edge_hit;
    logic sticky_mode;
    logic flag_q;

    assign bit_now = cur_i[sel_i];
    assign bit_old = prev_i[sel_i];
    assign rise    = bit_now & ~bit_old;
    assign fall    = ~bit_now & bit_old;

    // Pick the edge that feeds the sticky flag for the chosen code.
    always_comb begin
        edge_hit    = 1'b0;
        sticky_mode = 1'b0;
        unique case (cond_i)
            PM_RISE_ST: begin edge_hit = rise;        sticky_mode = 1'b1; end
            PM_FALL_ST: begin edge_hit = fall;        sticky_mode = 1'b1; end
            PM_EDGE_ST: begin edge_hit = rise | fall; sticky_mode = 1'b1; end
            default:    begin edge_hit = 1'b0;        sticky_mode = 1'b0; end
        endcase
    end

    // Evaluate the slice condition.
    always_comb begin
        unique case (cond_i)
            PM_ALWAYS:  ok_o = 1'b1;
            PM_RISE_ST,
            PM_FALL_ST,
            PM_EDGE_ST: ok_o = flag_q | edge_hit;
            PM_HIGH:    ok_o = bit_now;
            PM_LOW:     ok_o = ~bit_now;
            PM_NEVER:   ok_o = 1'b0;
            PM_EVENT:   ok_o = rise;
            default:    ok_o = 1'b0;
        endcase
    end

    // Remember a sticky edge until the owning term matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!enable_i || !sticky_mode || term_hit_i) begin
            flag_q <= 1'b0;
        end else if (edge_hit) begin
            flag_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pm_terms.sv
// Chains slices into product terms and reports each term's result.
// Assumes the last slice always closes a term. term_match_o is set at closing
// slices only; term_hit_o gives every slice the result of its own term.
module pm_terms #(
    parameter int unsigned NUM_SLICES = 8
) (
    input  logic [NUM_SLICES-1:0] ok_i,
    input  logic [NUM_SLICES-1:0] term_end_i,
    output logic [NUM_SLICES-1:0] term_match_o,
    output logic [NUM_SLICES-1:0] term_hit_o
);
    logic [NUM_SLICES-1:0] end_eff;

    assign end_eff = {1'b1, term_end_i[NUM_SLICES-2:0]};

    // Forward pass: AND slices until a closing slice, then restart.
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = 0; i < NUM_SLICES; i++) begin
            run = run & ok_i[i];
            term_match_o[i] = end_eff[i] & run;
            if (end_eff[i]) run = 1'b1;
        end
    end

    // Backward pass: hand each term's result to all of its slices.
    always_comb begin
        logic hold;
        hold = 1'b0;
        for (int i = NUM_SLICES - 1; i >= 0; i--) begin
            if (end_eff[i]) hold = term_match_o[i];
            term_hit_o[i] = hold;
        end
    end
endmodule

// File: rtl/pattern_match_engine.sv
// Boolean pattern match engine top. It synchronises the inputs, evaluates
// NUM_SLICES slices, ORs the product terms and registers the outputs.
// Assumes the configuration is driven synchronously; mode_i = 0 idles the engine.
module pattern_match_engine
    import pm_pkg::*;
#(
    parameter int unsigned NUM_IN     = 8,
    parameter int unsigned NUM_SLICES = 8,
    parameter int unsigned IDX_W      = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_i,
    input  logic [NUM_IN-1:0]           in_i,
    input  logic [NUM_SLICES*IDX_W-1:0] sel_i,
    input  logic [NUM_SLICES*3-1:0]     cond_i,
    input  logic [NUM_SLICES-1:0]       term_end_i,
    output logic [NUM_SLICES-1:0]       match_o,
    output logic                        irq_o
);
    localparam int unsigned CW = PM_COND_W;

    logic [NUM_IN-1:0]     cur;
    logic [NUM_IN-1:0]     prev;
    logic [NUM_SLICES-1:0] slice_ok;
    logic [NUM_SLICES-1:0] term_match;
    logic [NUM_SLICES-1:0] term_hit;
    logic [NUM_SLICES-1:0] match_q;
    logic                  irq_q;

    pm_sync #(.W(NUM_IN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (in_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        pm_slice #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable_i   (mode_i),
            .sel_i      (sel_i[s*IDX_W +: IDX_W]),
            .cond_i     (pm_cond_e'(cond_i[s*CW +: CW])),
            .cur_i      (cur),
            .prev_i     (prev),
            .term_hit_i (term_hit[s]),
            .ok_o       (slice_ok[s])
        );
    end

    pm_terms #(.NUM_SLICES(NUM_SLICES)) u_terms (
        .ok_i         (slice_ok),
        .term_end_i   (term_end_i),
        .term_match_o (term_match),
        .term_hit_o   (term_hit)
    );

    // Register the per-term matches and the interrupt, gated by mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            match_q <= mode_i ? term_match : '0;
            irq_q   <= mode_i & (|term_match);
        end
    end

    assign match_o = match_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/pattern_match_engine_chk.sv
// Checker for the pattern match engine, bound to the top. It relates the
// outputs to the configuration and mode sampled one edge earlier.
module pm_checker #(
    parameter int unsigned NUM_SLICES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mode_i,
    input logic [NUM_SLICES-1:0] term_end_i,
    input logic [NUM_SLICES-1:0] match_o,
    input logic                  irq_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (match_o == '0 && !irq_o));

    // R11
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_i) |-> (match_o == '0 && !irq_o));

    // R5
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|match_o));

    for (genvar i = 0; i < NUM_SLICES - 1; i++) begin : g_end
        // R5
        match_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[i] |-> $past(term_end_i[i]));
    end
endmodule

bind pattern_match_engine pm_checker #(.NUM_SLICES(NUM_SLICES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .term_end_i (term_end_i),
    .match_o    (match_o),
    .irq_o      (irq_o)
);

// File: tb/test_pattern_match_engine.sv
// Scoreboard bench: the driver pushes expected outputs for a given cycle; the
// monitor pops them and compares shortly after each rising edge.
module test_pattern_match_engine;
    localparam int NI = 8;
    localparam int NS = 8;
    localparam int IW = 3;

    localparam logic [2:0] C_ALWAYS = 3'b000;
    localparam logic [2:0] C_RISE   = 3'b001;
    localparam logic [2:0] C_FALL   = 3'b010;
    localparam logic [2:0] C_EDGE   = 3'b011;
    localparam logic [2:0] C_HIGH   = 3'b100;
    localparam logic [2:0] C_LOW    = 3'b101;
    localparam logic [2:0] C_NEVER  = 3'b110;
    localparam logic [2:0] C_EVENT  = 3'b111;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_i;
    logic [NI-1:0] in_i;
    logic [NS*IW-1:0] sel_i;
    logic [NS*3-1:0]  cond_i;
    logic [NS-1:0]    term_end_i;
    logic [NS-1:0]    match_o;
    logic             irq_o;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [7:0]  m;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t sb[$];

    pattern_match_engine #(.NUM_IN(NI), .NUM_SLICES(NS)) i_pattern_match_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .in_i       (in_i),
        .sel_i      (sel_i),
        .cond_i     (cond_i),
        .term_end_i (term_end_i),
        .match_o    (match_o),
        .irq_o      (irq_o)
    );

    always #5 clk = ~clk;

    // Monitor: count edges, then compare due items 3 ns later.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #3;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at != cyc || match_o !== e.m || irq_o !== e.irq) begin
                fails++;
                $display("FAIL %s cycle %0d: match=%h irq=%b expected match=%h irq=%b",
                         e.tag, e.at, match_o, irq_o, e.m, e.irq);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int dly, input logic [7:0] m, input logic irq,
                             input string tag);
        exp_t e;
        e.at = cyc + dly; e.m = m; e.irq = irq; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic set_slice(input int s, input int sel, input logic [2:0] c,
                             input logic e);
        sel_i[s*IW +: IW] = sel[IW-1:0];
        cond_i[s*3 +: 3]  = c;
        term_end_i[s]     = e;
    endtask

    task automatic clear_cfg();
        for (int s = 0; s < NS; s++) set_slice(s, 0, C_NEVER, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_i = 1'b1; in_i = '0;
        sel_i = '0; cond_i = '0; term_end_i = '0;
        clear_cfg();
        set_slice(0, 0, C_ALWAYS, 1'b1);
        step(2);
        // R1: outputs stay low during reset even with an always-true term
        expect_at(1, 8'h00, 1'b0, "R1");
        step(2);
        rst_n = 1'b1;
        expect_at(1, 8'h00, 1'b0, "R1");
        clear_cfg();
        step(4);

        // R12 and R2: slice 0 high on IN3
        set_slice(0, 3, C_HIGH, 1'b1);
        step(4);
        in_i = 8'h04;
        expect_at(3, 8'h00, 1'b0, "R12");
        step(4);
        in_i = 8'h08;
        expect_at(2, 8'h00, 1'b0, "R2");
        expect_at(3, 8'h01, 1'b1, "R2");
        step(4);
        in_i = 8'h00;
        expect_at(2, 8'h01, 1'b1, "R2");
        expect_at(3, 8'h00, 1'b0, "R2");
        step(4);

        // R3: low on IN5, config change visible after one edge
        set_slice(0, 5, C_LOW, 1'b1);
        expect_at(1, 8'h01, 1'b1, "R3");
        step(3);
        in_i = 8'h20;
        expect_at(2, 8'h01, 1'b1, "R3");
        expect_at(3, 8'h00, 1'b0, "R3");
        step(4);
        in_i = 8'h00;
        clear_cfg();
        step(4);

        // R4, R5: term {IN0 & IN1} closed at slice 1, term {IN2} at slice 2
        set_slice(0, 0, C_HIGH, 1'b0);
        set_slice(1, 1, C_HIGH, 1'b1);
        set_slice(2, 2, C_HIGH, 1'b1);
        step(2);
        in_i = 8'h01;
        expect_at(3, 8'h00, 1'b0, "R4");
        step(4);
        in_i = 8'h03;
        expect_at(3, 8'h02, 1'b1, "R4");
        step(4);
        in_i = 8'h04;
        expect_at(2, 8'h02, 1'b1, "R5");
        expect_at(3, 8'h04, 1'b1, "R5");
        step(4);
        in_i = 8'h07;
        expect_at(3, 8'h06, 1'b1, "R5");
        step(4);
        in_i = 8'h00;
        step(4);

        // R10: last slice closes its term with the end flag clear
        clear_cfg();
        set_slice(6, 0, C_ALWAYS, 1'b0);
        set_slice(7, 7, C_HIGH, 1'b0);
        step(2);
        in_i = 8'h80;
        expect_at(3, 8'h80, 1'b1, "R10");
        step(4);
        in_i = 8'h00;
        expect_at(3, 8'h00, 1'b0, "R10");
        step(4);

        // R6: sticky rising on IN0 with IN1 high
        clear_cfg();
        set_slice(0, 0, C_RISE, 1'b0);
        set_slice(1, 1, C_HIGH, 1'b1);
        step(2);
        in_i = 8'h01;
        step(1);
        in_i = 8'h00;
        expect_at(3, 8'h00, 1'b0, "R6");
        step(5);
        in_i = 8'h02;
        expect_at(3, 8'h02, 1'b1, "R6");
        expect_at(4, 8'h00, 1'b0, "R6");
        step(6);
        in_i = 8'h03;
        expect_at(3, 8'h02, 1'b1, "R6");
        expect_at(4, 8'h00, 1'b0, "R6");
        step(5);
        in_i = 8'h00;
        step(4);

        // R7: sticky falling, then sticky either edge, on IN2
        clear_cfg();
        set_slice(0, 2, C_FALL, 1'b1);
        step(2);
        in_i = 8'h04;
        expect_at(3, 8'h00, 1'b0, "R7");
        expect_at(4, 8'h00, 1'b0, "R7");
        step(5);
        in_i = 8'h00;
        expect_at(3, 8'h01, 1'b1, "R7");
        expect_at(4, 8'h00, 1'b0, "R7");
        step(5);
        set_slice(0, 2, C_EDGE, 1'b1);
        step(2);
        in_i = 8'h04;
        expect_at(3, 8'h01, 1'b1, "R7");
        expect_at(4, 8'h00, 1'b0, "R7");
        step(5);
        in_i = 8'h00;
        expect_at(3, 8'h01, 1'b1, "R7");
        expect_at(4, 8'h00, 1'b0, "R7");
        step(5);

        // R8: event on IN4 with IN1 high
        clear_cfg();
        set_slice(0, 4, C_EVENT, 1'b0);
        set_slice(1, 1, C_HIGH, 1'b1);
        in_i = 8'h02;
        step(4);
        in_i = 8'h12;
        expect_at(3, 8'h02, 1'b1, "R8");
        expect_at(4, 8'h00, 1'b0, "R8");
        step(5);
        in_i = 8'h02;
        expect_at(3, 8'h00, 1'b0, "R8");
        expect_at(4, 8'h00, 1'b0, "R8");
        step(5);
        in_i = 8'h10;
        step(5);
        in_i = 8'h12;
        expect_at(3, 8'h00, 1'b0, "R8");
        expect_at(4, 8'h00, 1'b0, "R8");
        step(5);
        in_i = 8'h00;
        step(4);

        // R9: always-true and never-true codes
        clear_cfg();
        step(2);
        set_slice(0, 0, C_ALWAYS, 1'b1);
        expect_at(1, 8'h01, 1'b1, "R9");
        step(3);
        set_slice(0, 0, C_NEVER, 1'b1);
        in_i = 8'hFF;
        expect_at(1, 8'h00, 1'b0, "R9");
        expect_at(3, 8'h00, 1'b0, "R9");
        step(4);
        in_i = 8'h00;
        step(4);

        // R11: mode off blocks outputs and sticky memory
        clear_cfg();
        set_slice(0, 0, C_RISE, 1'b0);
        set_slice(1, 1, C_HIGH, 1'b1);
        set_slice(2, 0, C_ALWAYS, 1'b1);
        mode_i = 1'b0;
        in_i = 8'h02;
        expect_at(1, 8'h00, 1'b0, "R11");
        step(4);
        in_i = 8'h03;
        expect_at(3, 8'h00, 1'b0, "R11");
        step(5);
        mode_i = 1'b1;
        expect_at(1, 8'h04, 1'b1, "R11");
        expect_at(2, 8'h04, 1'b1, "R11");
        step(3);
        in_i = 8'h02;
        step(4);
        in_i = 8'h03;
        expect_at(3, 8'h06, 1'b1, "R11");
        expect_at(4, 8'h04, 1'b1, "R11");
        step(6);

        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule